// File: doc/BRIEF.md
# Endpoint 0 Status Flag Register

This block keeps the four status flags of a USB device's control endpoint and presents them to a microcontroller as one read-only byte. The transaction engine reports events as single-cycle pulses: a STALL handshake has gone out, a SETUP packet has landed in the FIFO, OUT data has been stored, or a control transfer stage has completed. Each pulse sets its flag on the next clock edge. Firmware cannot write the flags directly. It clears a flag by writing a one to the matching bit of a separate acknowledge register, and a zero written there changes nothing.

A SETUP arrival outranks everything else. It sets its own flag and wipes the other three in the same edge, whatever else arrives in that cycle. While stored OUT data is waiting, the block asks the OUT token handler to NAK further OUT tokens, so the FIFO is not overwritten. A SETUP token is always accepted, even then. The three receive and transmit flags each drive an interrupt line gated by its own enable, and the OR of these lines forms a level-sensitive summary request.

Top module: `ep0_status`

## Requirements
- R1: After reset all eight status bits read zero, and bits 7 to 4 read zero at all times.
- R2: Status bit positions are: bit 3 stall-sent, bit 2 setup-received, bit 1 out-stored, bit 0 transfer-done. A pulse on `set_evt[i]` sets status bit i at the next edge. With no event and no acknowledge write, the byte holds.
- R3: A pulse on `set_evt[2]` leaves the status at exactly 4'b0100 in bits 3 to 0 after the next edge, whatever the other events and acknowledges in that cycle.
- R4: When `ack_wr` is high, a one in `ack_data[i]` (i = 0 to 3) clears status bit i at the next edge. Zeros in `ack_data`, and any `ack_data` while `ack_wr` is low, leave the flags unchanged. `ack_data[7:4]` is ignored.
- R5: If a set event and an acknowledge for the same bit arrive in one cycle, the bit ends up set.
- R6: `irq_vec[i]` for i = 0 to 2 equals status bit i AND `irq_en[i]`. The stall-sent flag raises no interrupt.
- R7: `irq` is the OR of `irq_vec`. It follows the flags as a level and falls in the cycle after the last enabled pending flag is acknowledged.
- R8: `nak_req` is high when the out-stored flag is set and `tok_is_setup` is low. A SETUP token (`tok_is_setup` high) never sees `nak_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_evt | input | 4 | Event pulses from the transaction engine, one per status bit |
| ack_wr | input | 1 | Write strobe for the acknowledge register |
| ack_data | input | 8 | Acknowledge data; a one in bits 3..0 clears the matching flag |
| irq_en | input | 3 | Interrupt enables for status bits 2..0 |
| tok_is_setup | input | 1 | Current token from the host is SETUP |
| status | output | 8 | Status byte read by firmware |
| irq_vec | output | 3 | Per-flag gated interrupt requests |
| irq | output | 1 | OR of all gated interrupt requests |
| nak_req | output | 1 | Request to answer the current OUT token with NAK |

## Verification
The bench visits every reachable flag state, every combination of event pulses, every acknowledge pattern, and both values of the write strobe. This exposes the collisions: SETUP together with other events or acknowledges, and set against clear on the same bit. If set did not beat clear, an event would be lost when firmware acknowledged in the same cycle. If SETUP failed to take priority, stale OUT or done flags would survive a new control transfer. A write with the strobe low or with zero bits must leave the byte unchanged, so a design that decoded the strobe loosely would drop flags here. For every resulting state, every enable mask and both token types are swept, to catch a stall flag that leaks into the interrupt or a NAK shown to a SETUP token.

// File: rtl/ep0_status.sv
module ep0_status #(
  parameter int NFLAG = 4,
  parameter int NIRQ  = 3,
  parameter int SETUP_BIT = 2,
  parameter int OUT_BIT   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set_evt,
  input  logic             ack_wr,
  input  logic [7:0]       ack_data,
  input  logic [NIRQ-1:0]  irq_en,
  input  logic             tok_is_setup,
  output logic [7:0]       status,
  output logic [NIRQ-1:0]  irq_vec,
  output logic             irq,
  output logic             nak_req
);

  localparam logic [NFLAG-1:0] SETUP_ONLY = NFLAG'(1) << SETUP_BIT;

  logic [NFLAG-1:0] flags;
  logic [NFLAG-1:0] clr;

  assign clr = ack_wr ? ack_data[NFLAG-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)                 flags <= '0;
    else if (set_evt[SETUP_BIT]) flags <= SETUP_ONLY;
    else                        flags <= set_evt | (flags & ~clr);
  end

  assign status  = {{(8-NFLAG){1'b0}}, flags};
  assign irq_vec = flags[NIRQ-1:0] & irq_en;
  assign irq     = |irq_vec;
  assign nak_req = flags[OUT_BIT] & ~tok_is_setup;

  // R3
  setup_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt[SETUP_BIT] |=> status[NFLAG-1:0] == SETUP_ONLY);

  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt[0] && !set_evt[SETUP_BIT] && ack_wr && ack_data[0] |=> status[0]);

  // R4
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[OUT_BIT] && ack_wr && ack_data[OUT_BIT] && set_evt == '0 |=> !status[OUT_BIT]);

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_wr && set_evt == '0 |=> $stable(status));

  // R7
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> |status[NIRQ-1:0]);

  // R8
  nak_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tok_is_setup |-> !nak_req);

endmodule

// File: tb/ep0_status_tb.sv
`timescale 1ns/1ps
module ep0_status_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [3:0] set_evt = 0;
  logic       ack_wr = 0;
  logic [7:0] ack_data = 0;
  logic [2:0] irq_en = 0;
  logic       tok_is_setup = 0;
  logic [7:0] status;
  logic [2:0] irq_vec;
  logic       irq;
  logic       nak_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ep0_status u_dut (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load(logic [3:0] s);
    @(negedge clk); set_evt = 0; ack_wr = 1; ack_data = 8'h0F;
    @(negedge clk); ack_wr = 0; set_evt = s[2] ? 4'b0100 : 4'b0000;
    @(negedge clk); set_evt = s & 4'b1011;
    @(negedge clk); set_evt = 0;
    chk("R2 load", status, {4'h0, s});
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", status, 8'h00);
    chk("R6 reset irq", {5'b0, irq_vec}, 8'h00);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", status, 8'h00);

    for (int s = 0; s < 16; s++)
      for (int ev = 0; ev < 16; ev++)
        for (int ak = 0; ak < 16; ak++)
          for (int wr = 0; wr < 2; wr++) begin
            logic [3:0] exp;
            logic [3:0] clr;
            load(4'(s));
            set_evt = 4'(ev);
            ack_wr = 1'(wr);
            ack_data = {4'(ak ^ 4'hA), 4'(ak)};
            clr = wr ? 4'(ak) : 4'h0;
            if (ev[2]) exp = 4'b0100;
            else exp = 4'(ev) | (4'(s) & ~clr);
            @(negedge clk);
            set_evt = 0; ack_wr = 0; ack_data = 0;
            if (ev[2]) chk("R3 setup wipe", status, {4'h0, exp});
            else if ((ev & ak & (wr ? 15 : 0)) != 0) chk("R5 set beats ack", status, {4'h0, exp});
            else chk("R4 ack clear", status, {4'h0, exp});
            for (int en = 0; en < 8; en++)
              for (int tk = 0; tk < 2; tk++) begin
                irq_en = 3'(en);
                tok_is_setup = 1'(tk);
                #0.2;
                chk("R6 irq_vec", {5'b0, irq_vec}, {5'b0, exp[2:0] & 3'(en)});
                chk("R7 irq", {7'b0, irq}, {7'b0, |(exp[2:0] & 3'(en))});
                chk("R8 nak", {7'b0, nak_req}, {7'b0, exp[1] & ~tk[0]});
              end
            irq_en = 0; tok_is_setup = 0;
          end

    load(4'b0111);
    irq_en = 3'b111;
    ack_wr = 1; ack_data = 8'h07;
    @(negedge clk);
    ack_wr = 0;
    chk("R7 irq falls after ack", {7'b0, irq}, 8'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule